// File: doc/BRIEF.md
# Lockable Translation Buffer with Victim Pointer

This block is a small, fully associative address translation cache for the memory management unit that sits in front of a device. Each slot holds a tag part and a data part. The tag part is a page-aligned virtual address, a two-bit page size code, a valid flag and a keep flag. The data part is a page-aligned physical base and an attribute field. Each lookup compares an address against every valid slot, and each comparison uses only the address bits above that slot's page boundary. The physical address returned is the slot's base joined with the untranslated low offset bits.

Software manages the buffer through a command port. It can write the lock register, read the slot under the victim pointer, load a new slot, flush the slots that cover an address, or flush everything. The lock register holds two fields. The base field splits the slots: those below the base are pinned, and those from the base up to the last slot form the replacement window. The victim field picks the slot that the next ordinary load fills. Replacement is round-robin inside the window only. A load marked "keep" is placed at the base slot, and the base then moves up by one.

Top module: `lock_tlb`

## Requirements
- R1: A lookup hits a valid slot when the address bits above the slot's page size agree with its tag. Page size codes are 00 = 4 KB, 01 = 64 KB, 10 = 1 MB and 11 = 16 MB. The returned physical address is the slot's base with the address's offset bits below that boundary.
- R2: When several valid slots match one lookup address, the slot with the lowest index supplies the result.
- R3: Lookup results are registered and appear one cycle after `lk_valid`. A lookup with no match raises `lk_miss` for exactly that one cycle, and `lk_hit` and `lk_miss` are never high together.
- R4: An ordinary load (op 3, keep = 0) writes the slot named by the victim field. If the victim is below the base, or not below the slot count, the slot at the base is written instead. The victim then becomes the written slot plus one, and it wraps to the base, not to zero, when that value equals the slot count.
- R5: A load with keep = 1 writes the slot at the base and sets that slot's keep flag. The base then rises by one, and the victim becomes the new base.
- R6: While the base is not below the slot count, every load (ordinary or keep) is refused. `load_busy` pulses for one cycle, and neither the slots nor the lock fields change.
- R7: The lock register view `lock_rdata` carries the base field at bits 14:10 and the victim field at bits 8:4, with every other bit zero. A lock write (op 1) loads both fields from `lock_wr_base` and `lock_wr_vict`.
- R8: A read command (op 2) returns, one cycle later and with `rd_done` high, the tag word and the data word of the slot under the victim pointer. The tag word has the virtual page bits 31:12, the valid flag at bit 3, the keep flag at bit 2 and the size code at bits 1:0. The data word has the physical page bits 31:12 and the attribute in its low bits. An invalid slot, or a victim not below the slot count, reads as two zero words.
- R9: An address flush (op 4) invalidates every valid slot whose range, from its start to its start plus its page size, contains `cmd_addr`. This includes pinned slots. The lock fields are left unchanged.
- R10: A global flush (op 5) invalidates all slots and sets both the base and the victim to zero.
- R11: After reset, every slot is invalid, both lock fields are zero, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe for one cycle |
| cmd_op | input | 3 | 1 lock write, 2 read, 3 load, 4 address flush, 5 global flush |
| lock_wr_base | input | LF_W | Base value for a lock write |
| lock_wr_vict | input | LF_W | Victim value for a lock write |
| cmd_addr | input | AW | Virtual address for a load or an address flush |
| cmd_pgsz | input | 2 | Page size code for a load |
| cmd_pa | input | AW | Physical address for a load |
| cmd_attr | input | ATTR_W | Attributes for a load |
| cmd_keep | input | 1 | Load into the pinned region |
| lock_rdata | output | 32 | Lock register view |
| rd_done | output | 1 | Read result valid |
| rd_cam | output | 32 | Tag word of the slot that was read |
| rd_ram | output | 32 | Data word of the slot that was read |
| load_busy | output | 1 | Load refused because every slot is pinned |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | AW | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss pulse |
| lk_pa | output | AW | Translated physical address |
| lk_attr | output | ATTR_W | Attributes of the hitting slot |

## Verification
The bench builds the block with ENTRIES = 8 and leaves the 32-bit addresses and the 4-bit attributes at their defaults. With only eight slots, a short run fills the pinned region and reaches the refused-load condition. It also makes the victim wrap to a non-zero base several times, and random lock writes often leave the victim below the base or past the end. Virtual pages are drawn from a 32 MB window, so 16 MB, 1 MB and 64 KB slots often overlap smaller ones. This exercises both the lowest-index rule and address flushes that remove several slots at once.

// File: rtl/lock_tlb_pkg.sv
package lock_tlb_pkg;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_LOCK_WR   = 3'd1,
    OP_READ      = 3'd2,
    OP_LOAD      = 3'd3,
    OP_FLUSH_VA  = 3'd4,
    OP_FLUSH_ALL = 3'd5
  } tlb_op_e;

  localparam int LOCK_BASE_LSB = 10;
  localparam int LOCK_VICT_LSB = 4;
  localparam int MIN_PAGE_BITS = 12;

  // log2 of the page size for a two-bit size code
  function automatic int pg_shift(input logic [1:0] sz);
    return MIN_PAGE_BITS + 4 * int'(sz);
  endfunction

endpackage

// File: rtl/lock_tlb_match.sv
module lock_tlb_match #(
  parameter int N  = 16,
  parameter int AW = 32
) (
  input  logic [N-1:0]  ent_v,
  input  logic [AW-1:0] ent_tag [N],
  input  logic [AW-1:0] ent_msk [N],
  input  logic [AW-1:0] probe,
  output logic [N-1:0]  hit
);

  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    assign hit[gi] = ent_v[gi] && (((probe ^ ent_tag[gi]) & ent_msk[gi]) == '0);
  end

endmodule

// File: rtl/lock_tlb_prio.sv
module lock_tlb_prio #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/lock_tlb_ctrl.sv
module lock_tlb_ctrl #(
  parameter int ENTRIES = 16,
  parameter int LF_W    = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            do_lock,
  input  logic [LF_W-1:0] wr_base,
  input  logic [LF_W-1:0] wr_vict,
  input  logic            do_load,
  input  logic            keep,
  input  logic            do_gflush,
  output logic [LF_W-1:0] base_q,
  output logic [LF_W-1:0] vict_q,
  output logic            load_go,
  output logic [LF_W-1:0] load_slot,
  output logic            busy_q
);

  localparam logic [LF_W-1:0] N_L = LF_W'(ENTRIES);

  logic            full;
  logic [LF_W-1:0] base_n, next_v, vict_n;

  always_comb begin
    full = (base_q >= N_L);
    load_go = do_load && !full;
    if (keep || vict_q < base_q || vict_q >= N_L) load_slot = base_q;
    else                                          load_slot = vict_q;
    base_n = keep ? base_q + 1'b1 : base_q;
    next_v = load_slot + 1'b1;
    vict_n = (next_v == N_L) ? base_n : next_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      vict_q <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= do_load && full;
      if (do_gflush) begin
        base_q <= '0;
        vict_q <= '0;
      end else if (do_lock) begin
        base_q <= wr_base;
        vict_q <= wr_vict;
      end else if (load_go) begin
        base_q <= base_n;
        vict_q <= vict_n;
      end
    end
  end

  // R4: after an accepted load the victim sits inside the window
  a_r4_vict_in_window: assert property (@(posedge clk) disable iff (rst)
    load_go |=> (vict_q >= base_q) && (vict_q <= N_L));

  // R5: a keep load moves the base up by exactly one
  a_r5_base_step: assert property (@(posedge clk) disable iff (rst)
    (load_go && keep) |=> base_q == LF_W'($past(base_q) + 1'b1));

  // R6: a refused load flags busy and leaves the lock fields alone
  a_r6_full_busy: assert property (@(posedge clk) disable iff (rst)
    (do_load && base_q >= N_L) |=> busy_q && base_q == $past(base_q) && vict_q == $past(vict_q));

  // R10: global flush clears both lock fields
  a_r10_lock_zero: assert property (@(posedge clk) disable iff (rst)
    do_gflush |=> base_q == '0 && vict_q == '0);

endmodule

// File: rtl/lock_tlb.sv
module lock_tlb
  import lock_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int AW      = 32,
  parameter int ATTR_W  = 4,
  parameter int LF_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [LF_W-1:0]   lock_wr_base,
  input  logic [LF_W-1:0]   lock_wr_vict,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [1:0]        cmd_pgsz,
  input  logic [AW-1:0]     cmd_pa,
  input  logic [ATTR_W-1:0] cmd_attr,
  input  logic              cmd_keep,
  output logic [31:0]       lock_rdata,
  output logic              rd_done,
  output logic [31:0]       rd_cam,
  output logic [31:0]       rd_ram,
  output logic              load_busy,
  input  logic              lk_valid,
  input  logic [AW-1:0]     lk_addr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [AW-1:0]     lk_pa,
  output logic [ATTR_W-1:0] lk_attr
);

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [LF_W-1:0] N_L = LF_W'(ENTRIES);
  localparam logic [31:0] PAGE_BITS = 32'hFFFF_F000;

  // slot storage: flags in flops, address and attribute words kept without reset
  logic [ENTRIES-1:0] ent_v, ent_k;
  logic [AW-1:0]      ent_va  [ENTRIES];
  logic [AW-1:0]      ent_pa  [ENTRIES];
  logic [AW-1:0]      ent_msk [ENTRIES];
  logic [1:0]         ent_sz  [ENTRIES];
  logic [ATTR_W-1:0]  ent_at  [ENTRIES];

  logic op_lock, op_read, op_load, op_flva, op_gfl;
  always_comb begin
    op_lock = cmd_valid && cmd_op == OP_LOCK_WR;
    op_read = cmd_valid && cmd_op == OP_READ;
    op_load = cmd_valid && cmd_op == OP_LOAD;
    op_flva = cmd_valid && cmd_op == OP_FLUSH_VA;
    op_gfl  = cmd_valid && cmd_op == OP_FLUSH_ALL;
  end

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_mask
    assign ent_msk[gi] = {AW{1'b1}} << pg_shift(ent_sz[gi]);
  end

  logic [LF_W-1:0] base_q, vict_q, load_slot;
  logic            load_go;

  lock_tlb_ctrl #(.ENTRIES(ENTRIES), .LF_W(LF_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .do_lock(op_lock), .wr_base(lock_wr_base), .wr_vict(lock_wr_vict),
    .do_load(op_load), .keep(cmd_keep), .do_gflush(op_gfl),
    .base_q(base_q), .vict_q(vict_q),
    .load_go(load_go), .load_slot(load_slot), .busy_q(load_busy)
  );

  assign lock_rdata = (32'(base_q) << LOCK_BASE_LSB) | (32'(vict_q) << LOCK_VICT_LSB);

  // lookup and address-flush comparators
  logic [ENTRIES-1:0] lk_hits, fl_hits;

  lock_tlb_match #(.N(ENTRIES), .AW(AW)) u_lk_match (
    .ent_v(ent_v), .ent_tag(ent_va), .ent_msk(ent_msk), .probe(lk_addr), .hit(lk_hits)
  );

  lock_tlb_match #(.N(ENTRIES), .AW(AW)) u_fl_match (
    .ent_v(ent_v), .ent_tag(ent_va), .ent_msk(ent_msk), .probe(cmd_addr), .hit(fl_hits)
  );

  logic          lk_any;
  logic [IW-1:0] lk_idx;

  lock_tlb_prio #(.N(ENTRIES), .IW(IW)) u_prio (
    .req(lk_hits), .any(lk_any), .idx(lk_idx)
  );

  // flag updates
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
      ent_k <= '0;
    end else if (op_gfl) begin
      ent_v <= '0;
      ent_k <= '0;
    end else if (op_flva) begin
      ent_v <= ent_v & ~fl_hits;
      ent_k <= ent_k & ~fl_hits;
    end else if (load_go) begin
      ent_v[load_slot[IW-1:0]] <= 1'b1;
      ent_k[load_slot[IW-1:0]] <= cmd_keep;
    end
  end

  // slot contents, one write port
  logic [AW-1:0] ld_msk;
  assign ld_msk = {AW{1'b1}} << pg_shift(cmd_pgsz);

  always_ff @(posedge clk) begin
    if (load_go) begin
      ent_va[load_slot[IW-1:0]] <= cmd_addr & ld_msk;
      ent_pa[load_slot[IW-1:0]] <= cmd_pa & ld_msk;
      ent_sz[load_slot[IW-1:0]] <= cmd_pgsz;
      ent_at[load_slot[IW-1:0]] <= cmd_attr;
    end
  end

  // read port at the victim pointer
  logic [IW-1:0] rd_idx;
  logic          rd_ok;
  assign rd_idx = vict_q[IW-1:0];
  assign rd_ok  = (vict_q < N_L) && ent_v[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_done <= 1'b0;
      rd_cam  <= '0;
      rd_ram  <= '0;
    end else begin
      rd_done <= op_read;
      if (op_read) begin
        if (rd_ok) begin
          rd_cam <= (32'(ent_va[rd_idx]) & PAGE_BITS) | {28'd0, 1'b1, ent_k[rd_idx], ent_sz[rd_idx]};
          rd_ram <= (32'(ent_pa[rd_idx]) & PAGE_BITS) | 32'(ent_at[rd_idx]);
        end else begin
          rd_cam <= '0;
          rd_ram <= '0;
        end
      end
    end
  end

  // registered lookup result
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit  <= 1'b0;
      lk_miss <= 1'b0;
      lk_pa   <= '0;
      lk_attr <= '0;
    end else begin
      lk_hit  <= lk_valid && lk_any;
      lk_miss <= lk_valid && !lk_any;
      if (lk_valid && lk_any) begin
        lk_pa   <= ent_pa[lk_idx] | (lk_addr & ~ent_msk[lk_idx]);
        lk_attr <= ent_at[lk_idx];
      end
    end
  end

  // R3: hit and miss are exclusive
  a_r3_hit_miss_excl: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_miss));

  // R3: a miss only follows a lookup request
  a_r3_miss_needs_req: assert property (@(posedge clk) disable iff (rst)
    lk_miss |-> $past(lk_valid));

  // R9: no slot covering the flushed address survives
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    op_flva |=> (ent_v & $past(fl_hits)) == '0);

  // R10: global flush empties the buffer
  a_r10_all_invalid: assert property (@(posedge clk) disable iff (rst)
    op_gfl |=> ent_v == '0);

  // R8: read data is flagged the cycle after the command
  a_r8_read_done: assert property (@(posedge clk) disable iff (rst)
    op_read |=> rd_done);

endmodule

// File: tb/lock_tlb_test.sv
module lock_tlb_test;

  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [4:0]  lock_wr_base = '0, lock_wr_vict = '0;
  logic [31:0] cmd_addr = '0, cmd_pa = '0;
  logic [1:0]  cmd_pgsz = '0;
  logic [3:0]  cmd_attr = '0;
  logic        cmd_keep = 1'b0;
  logic [31:0] lock_rdata, rd_cam, rd_ram;
  logic        rd_done, load_busy;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_pa;
  logic [3:0]  lk_attr;

  always #4 clk = ~clk;

  lock_tlb #(.ENTRIES(NE), .AW(32), .ATTR_W(4), .LF_W(5)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .lock_wr_base(lock_wr_base), .lock_wr_vict(lock_wr_vict),
    .cmd_addr(cmd_addr), .cmd_pgsz(cmd_pgsz), .cmd_pa(cmd_pa), .cmd_attr(cmd_attr),
    .cmd_keep(cmd_keep), .lock_rdata(lock_rdata), .rd_done(rd_done),
    .rd_cam(rd_cam), .rd_ram(rd_ram), .load_busy(load_busy),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_pa(lk_pa), .lk_attr(lk_attr)
  );

  int n_chk = 0, n_err = 0;

  // reference state
  int          mb = 0, mv = 0;
  bit          mval [NE];
  bit          mkeep[NE];
  logic [31:0] mva  [NE];
  logic [31:0] mpa  [NE];
  logic [1:0]  msz  [NE];
  logic [3:0]  mat  [NE];
  logic [31:0] last_va [4];

  function automatic logic [31:0] pmask(input logic [1:0] sz);
    return 32'hFFFF_FFFF << (12 + 4 * int'(sz));
  endfunction

  function automatic logic [31:0] exp_lock();
    return (32'(mb) << 10) | (32'(mv) << 4);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic m_reset();
    mb = 0; mv = 0;
    for (int i = 0; i < NE; i++) begin mval[i] = 0; mkeep[i] = 0; end
  endtask

  // drive one command at a negedge, check results at the next negedge
  task automatic do_cmd(input logic [2:0] op, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] pa, input logic [3:0] at, input bit keep,
                        input int b, input int v, input string req);
    bit          e_busy = 0;
    logic [31:0] e_cam = '0, e_ram = '0;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_pgsz = sz; cmd_pa = pa;
    cmd_attr = at; cmd_keep = keep; lock_wr_base = 5'(b); lock_wr_vict = 5'(v);
    case (op)
      3'd1: begin mb = b; mv = v; end
      3'd2: if (mv < NE && mval[mv]) begin
              e_cam = (mva[mv] & 32'hFFFF_F000) | {28'd0, 1'b1, mkeep[mv], msz[mv]};
              e_ram = (mpa[mv] & 32'hFFFF_F000) | 32'(mat[mv]);
            end
      3'd3: begin
              if (mb >= NE) e_busy = 1;
              else begin
                int slot, nv;
                slot = (keep || mv < mb || mv >= NE) ? mb : mv;
                mval[slot] = 1; mkeep[slot] = keep;
                mva[slot] = a & pmask(sz); mpa[slot] = pa & pmask(sz);
                msz[slot] = sz; mat[slot] = at;
                if (keep) mb++;
                nv = slot + 1;
                if (nv == NE) nv = mb;
                mv = nv;
              end
            end
      3'd4: for (int i = 0; i < NE; i++)
              if (mval[i] && ((a ^ mva[i]) & pmask(msz[i])) == 0) begin
                mval[i] = 0; mkeep[i] = 0;
              end
      3'd5: m_reset();
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(req, "lock_rdata", lock_rdata, exp_lock());
    chk(req, "load_busy", 32'(load_busy), 32'(e_busy));
    if (op == 3'd2) begin
      chk(req, "rd_done", 32'(rd_done), 32'd1);
      chk(req, "rd_cam", rd_cam, e_cam);
      chk(req, "rd_ram", rd_ram, e_ram);
    end
  endtask

  task automatic do_look(input logic [31:0] a, input string req);
    int          hi = -1;
    logic [31:0] e_pa = '0;
    for (int i = NE - 1; i >= 0; i--)
      if (mval[i] && ((a ^ mva[i]) & pmask(msz[i])) == 0) hi = i;
    if (hi >= 0) e_pa = mpa[hi] | (a & ~pmask(msz[hi]));
    lk_valid = 1'b1; lk_addr = a;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(req, "lk_hit", 32'(lk_hit), 32'(hi >= 0));
    chk(req, "lk_miss", 32'(lk_miss), 32'(hi < 0));
    if (hi >= 0) begin
      chk(req, "lk_pa", lk_pa, e_pa);
      chk(req, "lk_attr", 32'(lk_attr), 32'(mat[hi]));
    end
  endtask

  task automatic ld(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] pa,
                    input logic [3:0] at, input bit keep, input string req);
    do_cmd(3'd3, a, sz, pa, at, keep, 0, 0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R11: reset state
    chk("R11", "lock_rdata", lock_rdata, 32'h0);
    chk("R11", "lk_hit", 32'(lk_hit), 32'h0);
    chk("R11", "lk_miss", 32'(lk_miss), 32'h0);
    chk("R11", "load_busy", 32'(load_busy), 32'h0);
    do_cmd(3'd2, 0, 0, 0, 0, 0, 0, 0, "R11 read");
    do_look(32'h0001_0000, "R11 empty lookup");

    // R5: keep load at base
    ld(32'h0001_0abc, 2'd0, 32'h8000_0123, 4'h5, 1, "R5");
    chk("R5", "lock base1 vict1", lock_rdata, 32'h0000_0410);
    do_look(32'h0001_0abc, "R1 4K hit");
    chk("R1", "lk_pa", lk_pa, 32'h8000_0abc);

    // R4: fill the window then wrap to base
    for (int i = 0; i < 8; i++)
      ld(32'h0100_0000 + 32'(i) * 32'h1000, 2'd0, 32'h9000_0000 + 32'(i) * 32'h1000, 4'(i), 0, "R4 wrap");
    chk("R4", "vict after wrap", lock_rdata, 32'h0000_0420);

    // R7: lock write with victim below base
    do_cmd(3'd1, 0, 0, 0, 0, 0, 3, 1, "R7");
    chk("R7", "field positions", lock_rdata, 32'h0000_0c10);
    ld(32'h0200_0000, 2'd1, 32'hA000_0000, 4'h3, 0, "R4 victim below base");
    chk("R4", "slot redirected to base", lock_rdata, 32'h0000_0c40);
    do_cmd(3'd1, 0, 0, 0, 0, 0, 3, 3, "R7 set victim");
    do_cmd(3'd2, 0, 0, 0, 0, 0, 0, 0, "R8 read slot3");
    chk("R8", "cam literal", rd_cam, 32'h0200_0009);

    // R1 / R2: overlapping sizes and boundaries
    do_cmd(3'd5, 0, 0, 0, 0, 0, 0, 0, "R10");
    chk("R10", "lock zero", lock_rdata, 32'h0);
    do_look(32'h0001_0abc, "R10 all gone");
    ld(32'h0100_0000, 2'd3, 32'h4000_0000, 4'h1, 0, "R2 big");
    ld(32'h0100_5000, 2'd0, 32'h7000_0000, 4'h2, 0, "R2 small");
    do_look(32'h0100_5123, "R2 lowest index");
    chk("R2", "lk_pa", lk_pa, 32'h4000_5123);
    ld(32'h0002_0000, 2'd1, 32'h5001_0000, 4'h7, 0, "R1 64K");
    do_look(32'h0002_FFFF, "R1 top of 64K");
    chk("R1", "lk_pa", lk_pa, 32'h5001_FFFF);
    do_look(32'h0003_0000, "R1 past 64K");
    chk("R3", "miss", 32'(lk_miss), 32'h1);
    @(negedge clk);
    chk("R3", "miss one cycle", 32'(lk_miss), 32'h0);

    // R9: address flush removes every covering slot
    do_cmd(3'd4, 32'h0100_5FFF, 0, 0, 0, 0, 0, 0, "R9");
    chk("R9", "lock unchanged", lock_rdata, 32'h0000_0030);
    do_look(32'h0100_5123, "R9 both flushed");
    do_look(32'h0002_1000, "R9 other kept");

    // R6: fill the pinned region
    do_cmd(3'd5, 0, 0, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < NE; i++)
      ld(32'h0400_0000 + 32'(i) * 32'h10_0000, 2'd2, 32'hC000_0000 + 32'(i) * 32'h10_0000, 4'h9, 1, "R5 fill");
    chk("R6", "base full", lock_rdata, 32'h0000_2080);
    ld(32'h0800_0000, 2'd0, 32'h1, 4'h1, 1, "R6 keep refused");
    ld(32'h0800_0000, 2'd0, 32'h1, 4'h1, 0, "R6 plain refused");
    do_look(32'h0800_0000, "R6 nothing written");
    do_look(32'h0470_0001, "R6 pinned slot intact");
    do_cmd(3'd5, 0, 0, 0, 0, 0, 0, 0, "R10");

    // random mix
    for (int i = 0; i < 4; i++) last_va[i] = 32'h1000_0000;
    for (int n = 0; n < 1500; n++) begin
      int r;
      logic [31:0] a;
      r = int'($urandom_range(99, 0));
      a = 32'h1000_0000 + ($urandom() % 32'h0200_0000);
      if (r < 30) begin
        last_va[n % 4] = a;
        ld(a, 2'($urandom()), $urandom(), 4'($urandom()), 0, "R4 random");
      end else if (r < 37) begin
        ld(a, 2'($urandom()), $urandom(), 4'($urandom()), 1, "R5 random");
      end else if (r < 42) begin
        do_cmd(3'd1, 0, 0, 0, 0, 0, int'($urandom_range(9, 0)), int'($urandom_range(15, 0)), "R7 random");
      end else if (r < 52) begin
        do_cmd(3'd2, 0, 0, 0, 0, 0, 0, 0, "R8 random");
      end else if (r < 57) begin
        do_cmd(3'd4, (r & 1) ? a : last_va[n % 4] + 32'h10, 0, 0, 0, 0, 0, 0, "R9 random");
      end else if (r < 59) begin
        do_cmd(3'd5, 0, 0, 0, 0, 0, 0, 0, "R10 random");
      end else if (r < 80) begin
        do_look(last_va[$urandom() % 4] + ($urandom() % 32'h2000), "R1 random");
      end else begin
        do_look(a, "R2 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule